// File: doc/BRIEF.md
# Multi-Device SPI Transaction Master

This block runs one complete serial transaction for each start pulse, acting as the clock-driving end of a shared synchronous serial bus with seven attached devices. A request carries an eight-bit device mask, a format code, two header bytes, a direction and a byte count. The block checks the request before doing anything on the bus. A request that fails the check ends at once with an error, and no select or clock edge appears on the bus.

An accepted request raises the chosen device selects. The FPGA select is active high and every other select is active low. The block then shifts out zero, one or two header bytes, MSB first, followed by the data phase. The data phase either writes bytes from a four-entry buffer, reads bytes into it, or exchanges them in place. The host loads and inspects that buffer through a simple port while the engine is idle. Completion is reported by a one-cycle done pulse together with an error flag, and all selects are back at their inactive levels in that same cycle.

The serial clock half-period is a parameter counted in system clocks.

Top module: `spi_txn_master`

## Requirements
- R1: Mask bits [2:0] drive dev_sel[2:0] and mask bits [7:4] drive dev_sel[6:3]. Mask bit 3 drives no select. dev_sel[0] is active high and dev_sel[6:1] are active low, so the inactive pattern is 7'b1111110.
- R2: A read (dir=1) or exchange (dir=2) whose mask has more than one bit set, counting all eight bits, ends with an error. A write (dir=0) with several mask bits set runs normally and asserts every selected device.
- R3: The request is rejected when fmt[2]=1 (LSB first), when the header code fmt[1:0]=3, when dir=3, or when len>4. On rejection, done and err are high in the cycle after start, and no select or SCLK pulse is produced.
- R4: Header code fmt[1:0]=0 sends no header, 1 sends hdr_lo only, and 2 sends hdr_hi followed by hdr_lo. The data phase follows the header.
- R5: Bytes are sent MSB first. SCLK idles low. MOSI changes only while SCLK is low. Each SCLK high phase lasts CLK_DIV system clocks. MISO is sampled at the end of the high phase.
- R6: In a write, the data phase sends buffer entries 0 to len-1 in order and leaves the buffer unchanged.
- R7: In a read, MOSI is low during the data phase, and the k-th received data byte is stored in buffer entry k.
- R8: In an exchange, buffer entry k is sent as the k-th data byte and is then replaced by the byte received during it.
- R9: A transaction with len=0 performs only the header phase. With no header either, no SCLK pulse occurs.
- R10: done is a single-cycle pulse that ends every transaction. err is valid with done. All selects are inactive in the done cycle, and busy is high between acceptance and done.
- R11: A start pulse while busy is ignored. Host buffer writes while busy are ignored. buf_rdata shows the entry at buf_addr one cycle after the address is presented.
- R12: After reset, all selects are inactive, SCLK and MOSI are low, and busy and done are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a transaction (taken only when idle) |
| en_mask | input | 8 | Device mask, active high |
| fmt | input | 3 | [2] LSB-first request (rejected), [1:0] header code |
| dir | input | 2 | 0 write, 1 read, 2 exchange, 3 invalid |
| hdr_hi | input | 8 | High header byte |
| hdr_lo | input | 8 | Low header byte |
| len | input | 3 | Data byte count |
| buf_we | input | 1 | Host buffer write strobe |
| buf_addr | input | 2 | Host buffer address |
| buf_wdata | input | 8 | Host buffer write data |
| buf_rdata | output | 8 | Host buffer read data, registered |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Completion status, 1 = rejected |
| miso | input | 1 | Serial data from the device |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data to the device |
| dev_sel | output | 7 | Physical device selects, mixed polarity |

## Verification
A wrong select mapping or polarity shows on dev_sel at the first SCLK rise of the transaction, when the levels seen by the device model are compared with the mask. A validation fault shows one cycle after start: a wrongly refused request gives err, and a wrongly accepted one gives SCLK pulses or a select that leaves its idle level. A sequencing or buffer-index fault shows on the MOSI byte stream seen by the model and in the buffer readback right after done. A divider or phase fault shows within the first byte as a wrong high-phase length or a MOSI change while SCLK is high.

// File: rtl/spi_txn_pkg.sv
package spi_txn_pkg;
  localparam logic [1:0] DIR_WRITE = 2'd0;
  localparam logic [1:0] DIR_READ  = 2'd1;
  localparam logic [1:0] DIR_XCHG  = 2'd2;
  localparam logic [1:0] HDR_BAD   = 2'd3;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOAD = 2'd1,
    ST_WAIT = 2'd2,
    ST_END  = 2'd3
  } seq_state_e;
endpackage

// File: rtl/spi_txn_check.sv
module spi_txn_check
  import spi_txn_pkg::*;
#(
  parameter int MASK_W = 8,
  parameter int DEPTH  = 4,
  parameter int LEN_W  = 3
) (
  input  logic [MASK_W-1:0] mask,
  input  logic [2:0]        fmt,
  input  logic [1:0]        dir,
  input  logic [LEN_W-1:0]  len,
  output logic              ok,
  output logic [1:0]        hdr_n
);
  localparam int CNT_W = $clog2(MASK_W + 1);

  logic [CNT_W-1:0] ones;
  logic             multi, lsb_req, bad_hdr, bad_dir, too_long;

  always_comb begin
    ones = '0;
    for (int b = 0; b < MASK_W; b++) ones = ones + CNT_W'(mask[b]);
  end

  // R2: single-device rule only for transfers that read back
  assign multi    = (ones > CNT_W'(1)) && (dir != DIR_WRITE);
  // R3: format, direction and length rules
  assign lsb_req  = fmt[2];
  assign bad_hdr  = (fmt[1:0] == HDR_BAD);
  assign bad_dir  = (dir == 2'd3);
  assign too_long = (len > LEN_W'(DEPTH));
  assign ok       = !(multi || lsb_req || bad_hdr || bad_dir || too_long);
  assign hdr_n    = fmt[1:0];
endmodule

// File: rtl/spi_txn_selmap.sv
module spi_txn_selmap #(
  parameter int                 NUM_DEV  = 7,
  parameter logic [NUM_DEV-1:0] ACT_HIGH = NUM_DEV'(1)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               set,
  input  logic               clr,
  input  logic [NUM_DEV-1:0] req,
  output logic [NUM_DEV-1:0] sel
);
  // R1: each pin registered at its own idle level, flipped when requested
  for (genvar d = 0; d < NUM_DEV; d++) begin : g_pin
    localparam logic IDLE_L = ~ACT_HIGH[d];
    always_ff @(posedge clk) begin
      if (rst || clr) sel[d] <= IDLE_L;
      else if (set)   sel[d] <= IDLE_L ^ req[d];
    end
  end
endmodule

// File: rtl/spi_txn_shift.sv
module spi_txn_shift #(
  parameter int DIV = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       go,
  input  logic [7:0] tx,
  input  logic       miso,
  output logic       byte_done,
  output logic [7:0] rx,
  output logic       sclk,
  output logic       mosi
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;

  logic          act;
  logic [2:0]    bitc;
  logic [CW-1:0] dcnt;
  logic [7:0]    sh;

  always_ff @(posedge clk) begin
    if (rst) begin
      act <= 1'b0; bitc <= '0; dcnt <= '0; sh <= '0;
      rx <= '0; sclk <= 1'b0; mosi <= 1'b0; byte_done <= 1'b0;
    end else begin
      byte_done <= 1'b0;
      if (!act) begin
        if (go) begin
          act  <= 1'b1;
          mosi <= tx[7];
          sh   <= {tx[6:0], 1'b0};
          bitc <= '0;
          dcnt <= '0;
        end
      end else if (dcnt == CW'(DIV - 1)) begin
        dcnt <= '0;
        if (!sclk) begin
          sclk <= 1'b1;
        end else begin
          sclk <= 1'b0;
          rx   <= {rx[6:0], miso};
          if (bitc == 3'd7) begin
            act       <= 1'b0;
            byte_done <= 1'b1;
            mosi      <= 1'b0;
          end else begin
            bitc <= bitc + 3'd1;
            mosi <= sh[7];
            sh   <= {sh[6:0], 1'b0};
          end
        end
      end else begin
        dcnt <= dcnt + CW'(1);
      end
    end
  end

  assert_mosi_setup_R5: assert property (@(posedge clk) disable iff (rst)
    (sclk && $past(sclk)) |-> $stable(mosi));

  assert_done_after_fall_R5: assert property (@(posedge clk) disable iff (rst)
    byte_done |-> (!sclk && $past(sclk)));
endmodule

// File: rtl/spi_txn_master.sv
module spi_txn_master
  import spi_txn_pkg::*;
#(
  parameter int                 CLK_DIV  = 4,
  parameter int                 DEPTH    = 4,
  parameter int                 NUM_DEV  = 7,
  parameter int                 GAP_BIT  = 3,
  parameter logic [NUM_DEV-1:0] ACT_HIGH = NUM_DEV'(1),
  localparam int                MASK_W   = NUM_DEV + 1,
  localparam int                AW       = $clog2(DEPTH),
  localparam int                LEN_W    = $clog2(DEPTH + 1)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start,
  input  logic [MASK_W-1:0]  en_mask,
  input  logic [2:0]         fmt,
  input  logic [1:0]         dir,
  input  logic [7:0]         hdr_hi,
  input  logic [7:0]         hdr_lo,
  input  logic [LEN_W-1:0]   len,
  input  logic               buf_we,
  input  logic [AW-1:0]      buf_addr,
  input  logic [7:0]         buf_wdata,
  output logic [7:0]         buf_rdata,
  output logic               busy,
  output logic               done,
  output logic               err,
  input  logic               miso,
  output logic               sclk,
  output logic               mosi,
  output logic [NUM_DEV-1:0] dev_sel
);
  localparam logic [NUM_DEV-1:0] IDLE_LVL = ~ACT_HIGH;

  seq_state_e       st;
  logic [7:0]       mem [DEPTH];
  logic [1:0]       dir_q;
  logic [7:0]       hh_q, hl_q;
  logic [1:0]       hdr_left;
  logic [LEN_W-1:0] data_left;
  logic [AW-1:0]    idx;

  logic               req_ok, accept, go, byte_done, eng_we;
  logic [1:0]         hdr_n;
  logic [NUM_DEV-1:0] dev_req;
  logic [7:0]         tx_byte, rx_byte;

  // R1: skip the unused mask bit when mapping to pins
  for (genvar d = 0; d < NUM_DEV; d++) begin : g_req
    if (d < GAP_BIT) begin : g_lo
      assign dev_req[d] = en_mask[d];
    end else begin : g_hi
      assign dev_req[d] = en_mask[d+1];
    end
  end

  spi_txn_check #(.MASK_W(MASK_W), .DEPTH(DEPTH), .LEN_W(LEN_W)) u_check (
    .mask(en_mask), .fmt(fmt), .dir(dir), .len(len), .ok(req_ok), .hdr_n(hdr_n)
  );

  assign accept = (st == ST_IDLE) && start && req_ok;
  assign go     = (st == ST_LOAD) && ((hdr_left != 2'd0) || (data_left != '0));
  assign busy   = (st != ST_IDLE);

  spi_txn_selmap #(.NUM_DEV(NUM_DEV), .ACT_HIGH(ACT_HIGH)) u_sel (
    .clk(clk), .rst(rst), .set(accept), .clr(st == ST_END),
    .req(dev_req), .sel(dev_sel)
  );

  // R4/R6/R7: header bytes first (high before low), then data or zeros
  always_comb begin
    if (hdr_left == 2'd2)       tx_byte = hh_q;
    else if (hdr_left == 2'd1)  tx_byte = hl_q;
    else if (dir_q == DIR_READ) tx_byte = 8'h00;
    else                        tx_byte = mem[idx];
  end

  spi_txn_shift #(.DIV(CLK_DIV)) u_shift (
    .clk(clk), .rst(rst), .go(go), .tx(tx_byte), .miso(miso),
    .byte_done(byte_done), .rx(rx_byte), .sclk(sclk), .mosi(mosi)
  );

  // R7/R8: store received data bytes; R11: host writes only when idle
  assign eng_we = (st == ST_WAIT) && byte_done && (hdr_left == 2'd0) && (dir_q != DIR_WRITE);

  always_ff @(posedge clk) begin
    if (eng_we)                        mem[idx]      <= rx_byte;
    else if (st == ST_IDLE && buf_we)  mem[buf_addr] <= buf_wdata;
    buf_rdata <= mem[buf_addr];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= ST_IDLE; done <= 1'b0; err <= 1'b0;
      dir_q <= DIR_WRITE; hh_q <= '0; hl_q <= '0;
      hdr_left <= '0; data_left <= '0; idx <= '0;
    end else begin
      done <= 1'b0;
      case (st)
        ST_IDLE: if (start) begin
          if (req_ok) begin
            st        <= ST_LOAD;
            dir_q     <= dir;
            hh_q      <= hdr_hi;
            hl_q      <= hdr_lo;
            hdr_left  <= hdr_n;
            data_left <= len;
            idx       <= '0;
          end else begin
            done <= 1'b1;
            err  <= 1'b1;
          end
        end
        ST_LOAD: st <= go ? ST_WAIT : ST_END;
        ST_WAIT: if (byte_done) begin
          st <= ST_LOAD;
          if (hdr_left != 2'd0) begin
            hdr_left <= hdr_left - 2'd1;
          end else begin
            data_left <= data_left - LEN_W'(1);
            idx       <= idx + AW'(1);
          end
        end
        default: begin
          st   <= ST_IDLE;
          done <= 1'b1;
          err  <= 1'b0;
        end
      endcase
    end
  end

  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  assert_sel_idle_at_done_R10: assert property (@(posedge clk) disable iff (rst)
    done |-> (dev_sel == IDLE_LVL));

  assert_sclk_idle_R5: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !sclk);

  assert_reject_multi_R2: assert property (@(posedge clk) disable iff (rst)
    (!busy && start && (dir == DIR_READ || dir == DIR_XCHG) && $countones(en_mask) > 1)
      |=> (done && err && dev_sel == IDLE_LVL));

  assert_reject_lsb_R3: assert property (@(posedge clk) disable iff (rst)
    (!busy && start && fmt[2]) |=> (done && err && !busy));
endmodule

// File: tb/spi_txn_master_tb.sv
module spi_txn_master_tb_top;
  localparam int DIV = 3;
  localparam logic [6:0] IDLE = 7'b1111110;

  logic clk = 1'b0, rst = 1'b1, start = 1'b0, buf_we = 1'b0, miso = 1'b0;
  logic [7:0] en_mask = '0, hdr_hi = '0, hdr_lo = '0, buf_wdata = '0, buf_rdata;
  logic [2:0] fmt = '0, len = '0;
  logic [1:0] dir = '0, buf_addr = '0;
  logic busy, done, err, sclk, mosi;
  logic [6:0] dev_sel;

  always #10 clk = ~clk;

  spi_txn_master #(.CLK_DIV(DIV)) dut_i (
    .clk(clk), .rst(rst), .start(start), .en_mask(en_mask), .fmt(fmt), .dir(dir),
    .hdr_hi(hdr_hi), .hdr_lo(hdr_lo), .len(len), .buf_we(buf_we), .buf_addr(buf_addr),
    .buf_wdata(buf_wdata), .buf_rdata(buf_rdata), .busy(busy), .done(done), .err(err),
    .miso(miso), .sclk(sclk), .mosi(mosi), .dev_sel(dev_sel)
  );

  int n_chk = 0, n_err = 0, cyc = 0;
  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // device model
  logic [7:0] s_tx [8];
  logic [7:0] m_log [8];
  logic [7:0] s_rx;
  logic [6:0] sel_seen;
  int s_bi, s_bit, m_cnt, rbit, rises = 0, done_cnt = 0;
  int hi_run = 0, viol_hi = 0, viol_mosi = 0;
  bit sel_touch;
  logic prev_sclk = 1'b0, prev_mosi = 1'b0;

  always @(posedge sclk) begin
    s_rx = {s_rx[6:0], mosi};
    sel_seen = dev_sel;
    rises++;
    rbit++;
    if (rbit == 8) begin
      m_log[m_cnt[2:0]] = s_rx;
      m_cnt++;
      rbit = 0;
    end
  end

  always @(negedge sclk) begin
    #2;
    s_bit++;
    if (s_bit == 8) begin s_bit = 0; s_bi++; end
    miso = s_tx[s_bi[2:0]][3'(7 - s_bit)];
  end

  always @(posedge clk) begin
    #1;
    cyc++;
    if (done) done_cnt++;
    if (dev_sel != IDLE) sel_touch = 1'b1;
    if (sclk) hi_run++;
    else begin
      if (hi_run != 0 && hi_run != DIV) viol_hi++;
      hi_run = 0;
    end
    if (sclk && prev_sclk && mosi != prev_mosi) viol_mosi++;
    prev_sclk = sclk;
    prev_mosi = mosi;
  end

  task automatic wr_buf(input int a, input logic [7:0] v);
    @(negedge clk); buf_we = 1'b1; buf_addr = 2'(a); buf_wdata = v;
    @(negedge clk); buf_we = 1'b0;
  endtask

  task automatic rd_buf(input int a, output logic [7:0] v);
    @(negedge clk); buf_addr = 2'(a);
    @(negedge clk); v = buf_rdata;
  endtask

  function automatic bit exp_err(logic [7:0] m, logic [2:0] f, logic [1:0] d, logic [2:0] n);
    int c = 0;
    for (int b = 0; b < 8; b++) c += int'(m[b]);
    return f[2] || f[1:0] == 2'd3 || d == 2'd3 || n > 3'd4 || (d != 2'd0 && c > 1);
  endfunction

  function automatic logic [6:0] exp_sel(logic [7:0] m);
    return {m[7:4], m[2:0]} ^ IDLE;
  endfunction

  task automatic run_txn(input logic [7:0] m, input logic [2:0] f, input logic [1:0] d,
                         input logic [7:0] hh, input logic [7:0] hl, input logic [2:0] n,
                         input bit interfere);
    logic [7:0] pre [4];
    logic [7:0] exp_mosi [8];
    logic [7:0] v;
    bit e;
    int hn, nexp, r0, dc0, waitc;
    for (int k = 0; k < 4; k++) begin pre[k] = 8'($urandom); wr_buf(k, pre[k]); end
    for (int k = 0; k < 8; k++) s_tx[k] = 8'($urandom);
    e = exp_err(m, f, d, n);
    hn = int'(f[1:0]);
    nexp = 0;
    if (!e) begin
      if (hn == 2) begin exp_mosi[0] = hh; exp_mosi[1] = hl; end
      if (hn == 1) exp_mosi[0] = hl;
      for (int k = 0; k < int'(n); k++) exp_mosi[hn + k] = (d == 2'd1) ? 8'h00 : pre[k];
      nexp = hn + int'(n);
    end
    s_bi = 0; s_bit = 0; m_cnt = 0; rbit = 0; miso = s_tx[0][7];
    sel_seen = IDLE;
    @(negedge clk);
    sel_touch = 1'b0; r0 = rises; dc0 = done_cnt;
    en_mask = m; fmt = f; dir = d; hdr_hi = hh; hdr_lo = hl; len = n; start = 1'b1;
    waitc = 0;
    forever begin
      @(negedge clk);
      start = 1'b0; buf_we = 1'b0;
      if (interfere && waitc == 8) begin
        start = 1'b1; dir = 2'd2; fmt = 3'd0; len = 3'd1;
        buf_we = 1'b1; buf_addr = 2'd3; buf_wdata = 8'hEE;
      end
      if (done || waitc > 5000) break;
      waitc++;
    end
    chk(done == 1'b1, "R10 done seen", int'(done), 1);
    chk(err == e, "R3 err flag", int'(err), int'(e));
    chk(dev_sel == IDLE, "R10 selects idle at done", int'(dev_sel), int'(IDLE));
    @(negedge clk);
    chk(done_cnt - dc0 == 1, "R10 single done pulse", done_cnt - dc0, 1);
    chk(m_cnt == nexp, "R9 byte count", m_cnt, nexp);
    for (int k = 0; k < nexp && k < m_cnt; k++)
      chk(m_log[k] == exp_mosi[k], "R4 mosi byte", int'(m_log[k]), int'(exp_mosi[k]));
    if (e) begin
      chk(rises == r0, "R3 no sclk on reject", rises - r0, 0);
      chk(!sel_touch, "R2 no select on reject", int'(sel_touch), 0);
    end else if (nexp > 0) begin
      chk(sel_seen == exp_sel(m), "R1 select levels", int'(sel_seen), int'(exp_sel(m)));
    end
    for (int k = 0; k < 4; k++) begin
      logic [7:0] x;
      x = pre[k];
      if (!e && d != 2'd0 && k < int'(n)) x = s_tx[hn + k];
      rd_buf(k, v);
      chk(v == x, "R8 R7 R11 buffer entry", int'(v), int'(x));
    end
  endtask

  initial begin
    void'($urandom(32'h5eed));
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(dev_sel == IDLE, "R12 reset selects", int'(dev_sel), int'(IDLE));
    chk(!sclk && !mosi, "R12 reset sclk mosi", int'({sclk, mosi}), 0);
    chk(!busy && !done, "R12 reset busy done", int'({busy, done}), 0);

    run_txn(8'h01, 3'd1, 2'd0, 8'hA5, 8'h3C, 3'd0, 1'b0);   // R9 header only
    run_txn(8'h00, 3'd0, 2'd0, 8'h00, 8'h00, 3'd0, 1'b0);   // R9 nothing at all
    run_txn(8'hF7, 3'd2, 2'd0, 8'h81, 8'h7E, 3'd4, 1'b0);   // R2 write multi, R6
    run_txn(8'h10, 3'd1, 2'd1, 8'h12, 8'h34, 3'd4, 1'b0);   // R7
    run_txn(8'h80, 3'd0, 2'd2, 8'h00, 8'h00, 3'd4, 1'b0);   // R8
    run_txn(8'h04, 3'd0, 2'd2, 8'h00, 8'h00, 3'd5, 1'b0);   // R3 long
    run_txn(8'h03, 3'd0, 2'd1, 8'h00, 8'h00, 3'd2, 1'b0);   // R2 reject
    run_txn(8'h01, 3'd4, 2'd0, 8'h00, 8'h00, 3'd1, 1'b0);   // R3 lsb
    run_txn(8'h01, 3'd3, 2'd0, 8'h00, 8'h00, 3'd1, 1'b0);   // R3 header code
    run_txn(8'h01, 3'd0, 2'd3, 8'h00, 8'h00, 3'd1, 1'b0);   // R3 dir
    run_txn(8'h08, 3'd0, 2'd1, 8'h00, 8'h00, 3'd1, 1'b0);   // R1 bit 3 drives nothing
    run_txn(8'h02, 3'd2, 2'd0, 8'hC3, 8'h5A, 3'd4, 1'b1);   // R11 busy interference

    for (int i = 0; i < 60; i++) begin
      logic [7:0] m;
      logic [2:0] f, n;
      logic [1:0] d;
      case ($urandom % 3)
        0: m = 8'(1 << ($urandom % 8));
        1: m = 8'($urandom);
        default: m = 8'h00;
      endcase
      f = ($urandom % 5 == 0) ? 3'($urandom) : 3'($urandom % 3);
      d = ($urandom % 6 == 0) ? 2'd3 : 2'($urandom % 3);
      n = ($urandom % 6 == 0) ? 3'($urandom) : 3'($urandom % 5);
      run_txn(m, f, d, 8'($urandom), 8'($urandom), n, 1'b0);
    end

    chk(viol_hi == 0, "R5 high phase length", viol_hi, 0);
    chk(viol_mosi == 0, "R5 mosi stable while high", viol_mosi, 0);
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    wait (cyc > 150000);
    n_chk++;
    n_err++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule